// File: doc/BRIEF.md
# Per-Message Transmit Delivery Tracker

This block holds reliable-delivery state for a fixed set of outgoing messages. It sits between an application that streams message words and the packet scheduler that moves packets onto the wire. For every message slot it keeps three bitmaps with one bit per packet. The first marks packets the peer has acknowledged. The second marks packets that still have to go out, whether for the first time or again. The third marks packets the congestion window currently lets through. A packet is offered for sending only when both its pending bit and its credit bit are set.

The first word of a new message claims the lowest free slot and requests a timer start for that slot. Words are grouped into packets of `MTU_WORDS` words. A packet closes when it is full or when the message ends, and then becomes pending. Peer control events carry an opcode, a slot and a packet index, and update the bitmaps. A timeout notice makes every formed packet that is not yet acknowledged pending again. When a fully received message has every packet acknowledged, the slot is released and a timer cancel is requested. Payload storage, header building, the timer and the congestion policy live elsewhere.

Top module: `msg_tx_tracker`

## Requirements
- R1: After reset no slot is active: `desc_valid`, `tstart_valid` and `tcancel_valid` are low and `msg_ready` is high.
- R2: A word accepted while no message is open claims the lowest free slot. `tstart_valid` is high in that same cycle, with `tstart_slot` set to the slot claimed.
- R3: A packet closes after `MTU_WORDS` accepted words or on the word marked `msg_last`. Packet indices start at 0 and increase by one per packet. `desc_words` is `MTU_WORDS` for every packet except the last packet of a message, which reports its own word count, and `desc_last` is high only on that last packet.
- R4: At allocation, packets with index below `INIT_CREDIT` hold credit. A closed packet that has no credit is not offered.
- R5: A credit event (`ev_op` = 2'b01) grants credit to every packet of the slot whose index is at most `ev_pkt`. Pending packets that gain credit are then offered.
- R6: At most one descriptor is offered per cycle. It is taken from the lowest-numbered slot that has a sendable packet, and within that slot from the lowest packet index. A descriptor accepted with `desc_ready` clears that packet's pending bit, so the packet is not offered again.
- R7: A retransmit event (`ev_op` = 2'b10) makes the packet pending again if it is closed and not acknowledged. The event has no effect on an acknowledged packet or on a packet that has not closed yet.
- R8: An acknowledge event (`ev_op` = 2'b00) on a closed packet marks it delivered and removes it from pending.
- R9: A timeout (`to_valid`, `to_slot`) makes every closed, unacknowledged packet of that slot pending again.
- R10: When every packet of a fully received message has been acknowledged, `tcancel_valid` rises with `tcancel_slot` set to that slot. This happens in the cycle after the clock edge that applied the final acknowledge. The slot becomes free one edge later.
- R11: With no message open and every slot active, `msg_ready` is low and no word is taken.
- R12: Events addressed to an inactive slot, and events with `ev_op` = 2'b11, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Application offers one message word |
| msg_last | input | 1 | Offered word ends its message |
| msg_ready | output | 1 | Word is accepted this cycle |
| ev_valid | input | 1 | Peer control event present |
| ev_op | input | 2 | 00 ack, 01 credit up to index, 10 retransmit, 11 none |
| ev_slot | input | $clog2(N_SLOTS) | Slot addressed by the event |
| ev_pkt | input | $clog2(MAX_PKTS) | Packet index carried by the event |
| to_valid | input | 1 | Timer expiry notice |
| to_slot | input | $clog2(N_SLOTS) | Slot whose timer expired |
| desc_valid | output | 1 | Packet descriptor offered |
| desc_ready | input | 1 | Descriptor taken by the scheduler |
| desc_slot | output | $clog2(N_SLOTS) | Slot of the offered packet |
| desc_pkt | output | $clog2(MAX_PKTS) | Index of the offered packet |
| desc_words | output | $clog2(MTU_WORDS+1) | Word count of the offered packet |
| desc_last | output | 1 | Offered packet ends its message |
| tstart_valid | output | 1 | Timer start request |
| tstart_slot | output | $clog2(N_SLOTS) | Slot whose timer starts |
| tcancel_valid | output | 1 | Timer cancel request |
| tcancel_slot | output | $clog2(N_SLOTS) | Slot whose timer stops |

## Verification
A wrong bitmap bit shows up at the descriptor port within one cycle. If a packet is dropped or sent twice, the offered index sequence has a gap or a repeat. If a packet is released without credit, it appears before its grant. A delivered bit that is lost or set too early moves the timer-cancel pulse away from the cycle right after the final acknowledge. A leaked slot appears as a wrong `tstart_slot` or as stalled `msg_ready` when the next message starts.

// File: rtl/msgtx_pkg.sv
package msgtx_pkg;

   typedef enum logic [1:0] {
      EV_ACK    = 2'b00,
      EV_CREDIT = 2'b01,
      EV_RETX   = 2'b10,
      EV_NOP    = 2'b11
   } ev_op_e;

endpackage

// File: rtl/msgtx_pick.sv
// Lowest-index-first selector over a request vector.
module msgtx_pick #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   always_comb begin
      if (any) a_r6_pick_hit : assert (req[idx]);
   end

endmodule

// File: rtl/msgtx_intake.sv
// Word intake: slot allocation and packet closing.
module msgtx_intake #(
   parameter int N_SLOTS   = 4,
   parameter int MAX_PKTS  = 8,
   parameter int MTU_WORDS = 4,
   localparam int SLOT_W = $clog2(N_SLOTS),
   localparam int PKT_W  = $clog2(MAX_PKTS),
   localparam int LEN_W  = $clog2(MTU_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_valid,
   input  logic              msg_last,
   output logic              msg_ready,
   input  logic [N_SLOTS-1:0] free_mask,
   output logic              alloc,
   output logic [SLOT_W-1:0] tgt_slot,
   output logic              close,
   output logic [PKT_W-1:0]  close_idx,
   output logic [LEN_W-1:0]  close_len,
   output logic              close_end
);

   logic              open_q;
   logic [SLOT_W-1:0] cur_q;
   logic [LEN_W-1:0]  wcnt_q;
   logic [PKT_W-1:0]  pidx_q;
   logic              free_any;
   logic [SLOT_W-1:0] free_idx;
   logic              accept;

   msgtx_pick #(.N(N_SLOTS)) u_free_pick (
      .req (free_mask),
      .any (free_any),
      .idx (free_idx)
   );

   assign msg_ready = open_q | free_any;
   assign accept    = msg_valid & msg_ready;
   assign alloc     = accept & ~open_q;
   assign tgt_slot  = open_q ? cur_q : free_idx;
   assign close     = accept & (msg_last | (wcnt_q == LEN_W'(MTU_WORDS - 1)));
   assign close_idx = pidx_q;
   assign close_len = wcnt_q + LEN_W'(1);
   assign close_end = msg_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cur_q  <= '0;
         wcnt_q <= '0;
         pidx_q <= '0;
      end else if (accept) begin
         if (msg_last) begin
            open_q <= 1'b0;
            wcnt_q <= '0;
            pidx_q <= '0;
         end else begin
            open_q <= 1'b1;
            if (!open_q) cur_q <= free_idx;
            if (close) begin
               wcnt_q <= '0;
               pidx_q <= pidx_q + PKT_W'(1);
            end else begin
               wcnt_q <= wcnt_q + LEN_W'(1);
            end
         end
      end
   end

   a_r3_pkt_bound : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pidx_q == PKT_W'(MAX_PKTS - 1) && wcnt_q == LEN_W'(MTU_WORDS - 1)) |-> msg_last);

   a_r2_alloc_free : assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> free_mask[free_idx]);

   a_r2_open_holds_slot : assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && $past(open_q)) |-> $stable(cur_q));

endmodule

// File: rtl/msgtx_slot.sv
// State of one message slot: delivered, pending and credit bitmaps.
module msgtx_slot
   import msgtx_pkg::*;
#(
   parameter int MAX_PKTS    = 8,
   parameter int MTU_WORDS   = 4,
   parameter int INIT_CREDIT = 2,
   localparam int PKT_W = $clog2(MAX_PKTS),
   localparam int LEN_W = $clog2(MTU_WORDS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc_i,
   input  logic                close_i,
   input  logic [PKT_W-1:0]    close_idx_i,
   input  logic [LEN_W-1:0]    close_len_i,
   input  logic                close_end_i,
   input  logic                ev_hit_i,
   input  ev_op_e              ev_op_i,
   input  logic [PKT_W-1:0]    ev_pkt_i,
   input  logic                to_hit_i,
   input  logic                send_i,
   input  logic [PKT_W-1:0]    send_idx_i,
   input  logic                free_i,
   output logic                active_o,
   output logic [MAX_PKTS-1:0] pend_o,
   output logic                done_o,
   output logic                rx_done_o,
   output logic [PKT_W-1:0]    last_idx_o,
   output logic [LEN_W-1:0]    last_len_o
);

   localparam logic [MAX_PKTS-1:0] CRED0 =
      MAX_PKTS'((64'(1) << INIT_CREDIT) - 64'(1));

   logic                act_q, act_d;
   logic                rxd_q, rxd_d;
   logic [MAX_PKTS-1:0] dlv_q, dlv_d;
   logic [MAX_PKTS-1:0] tx_q, tx_d;
   logic [MAX_PKTS-1:0] crd_q, crd_d;
   logic [MAX_PKTS-1:0] frm_q, frm_d;
   logic [PKT_W-1:0]    lidx_q, lidx_d;
   logic [LEN_W-1:0]    llen_q, llen_d;

   always_comb begin
      act_d  = act_q;
      rxd_d  = rxd_q;
      dlv_d  = dlv_q;
      tx_d   = tx_q;
      crd_d  = crd_q;
      frm_d  = frm_q;
      lidx_d = lidx_q;
      llen_d = llen_q;

      if (send_i) tx_d[send_idx_i] = 1'b0;

      if (act_q && to_hit_i) tx_d = tx_d | (frm_q & ~dlv_q);

      if (act_q && ev_hit_i) begin
         case (ev_op_i)
            EV_ACK: begin
               if (frm_q[ev_pkt_i]) begin
                  dlv_d[ev_pkt_i] = 1'b1;
                  tx_d[ev_pkt_i]  = 1'b0;
               end
            end
            EV_CREDIT: begin
               for (int i = 0; i < MAX_PKTS; i++) begin
                  if (PKT_W'(i) <= ev_pkt_i) crd_d[i] = 1'b1;
               end
            end
            EV_RETX: begin
               if (frm_q[ev_pkt_i] && !dlv_q[ev_pkt_i]) tx_d[ev_pkt_i] = 1'b1;
            end
            default: ;
         endcase
      end

      if (alloc_i) begin
         act_d = 1'b1;
         rxd_d = 1'b0;
         dlv_d = '0;
         tx_d  = '0;
         crd_d = CRED0;
         frm_d = '0;
      end

      if (close_i) begin
         frm_d[close_idx_i] = 1'b1;
         tx_d[close_idx_i]  = 1'b1;
         if (close_end_i) begin
            rxd_d  = 1'b1;
            lidx_d = close_idx_i;
            llen_d = close_len_i;
         end
      end

      if (free_i) act_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         rxd_q  <= 1'b0;
         dlv_q  <= '0;
         tx_q   <= '0;
         crd_q  <= '0;
         frm_q  <= '0;
         lidx_q <= '0;
         llen_q <= '0;
      end else begin
         act_q  <= act_d;
         rxd_q  <= rxd_d;
         dlv_q  <= dlv_d;
         tx_q   <= tx_d;
         crd_q  <= crd_d;
         frm_q  <= frm_d;
         lidx_q <= lidx_d;
         llen_q <= llen_d;
      end
   end

   assign active_o   = act_q;
   assign pend_o     = act_q ? (tx_q & crd_q) : '0;
   assign done_o     = act_q & rxd_q & ((frm_q & ~dlv_q) == '0);
   assign rx_done_o  = rxd_q;
   assign last_idx_o = lidx_q;
   assign last_len_o = llen_q;

   a_r8_delivered_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act_q) && act_q) |-> ((dlv_q & $past(dlv_q)) == $past(dlv_q)));

   a_r5_credit_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act_q) && act_q) |-> ((crd_q & $past(crd_q)) == $past(crd_q)));

   a_r6_send_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (send_i && !to_hit_i && !(ev_hit_i && ev_op_i == EV_RETX)) |=> !tx_q[$past(send_idx_i)]);

   a_r2_alloc_only_free : assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> !act_q);

   a_r10_done_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !free_i) |=> done_o);

endmodule

// File: rtl/msg_tx_tracker.sv
// Top: per-message transmit delivery tracker.
module msg_tx_tracker
   import msgtx_pkg::*;
#(
   parameter int N_SLOTS     = 4,
   parameter int MAX_PKTS    = 8,
   parameter int MTU_WORDS   = 4,
   parameter int INIT_CREDIT = 2,
   localparam int SLOT_W = $clog2(N_SLOTS),
   localparam int PKT_W  = $clog2(MAX_PKTS),
   localparam int LEN_W  = $clog2(MTU_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_valid,
   input  logic              msg_last,
   output logic              msg_ready,
   input  logic              ev_valid,
   input  logic [1:0]        ev_op,
   input  logic [SLOT_W-1:0] ev_slot,
   input  logic [PKT_W-1:0]  ev_pkt,
   input  logic              to_valid,
   input  logic [SLOT_W-1:0] to_slot,
   output logic              desc_valid,
   input  logic              desc_ready,
   output logic [SLOT_W-1:0] desc_slot,
   output logic [PKT_W-1:0]  desc_pkt,
   output logic [LEN_W-1:0]  desc_words,
   output logic              desc_last,
   output logic              tstart_valid,
   output logic [SLOT_W-1:0] tstart_slot,
   output logic              tcancel_valid,
   output logic [SLOT_W-1:0] tcancel_slot
);

   if (N_SLOTS < 2) begin : g_bad_slots
      $error("N_SLOTS must be at least 2");
   end
   if (MAX_PKTS < 2 || MAX_PKTS > 32) begin : g_bad_pkts
      $error("MAX_PKTS must lie in 2..32");
   end
   if (MTU_WORDS < 1) begin : g_bad_mtu
      $error("MTU_WORDS must be at least 1");
   end
   if (INIT_CREDIT < 0 || INIT_CREDIT > MAX_PKTS) begin : g_bad_credit
      $error("INIT_CREDIT must lie in 0..MAX_PKTS");
   end

   logic                alloc;
   logic [SLOT_W-1:0]   tgt_slot;
   logic                close;
   logic [PKT_W-1:0]    close_idx;
   logic [LEN_W-1:0]    close_len;
   logic                close_end;

   logic [N_SLOTS-1:0]  act;
   logic [N_SLOTS-1:0]  done;
   logic [N_SLOTS-1:0]  rxd;
   logic [N_SLOTS-1:0]  has_pend;
   logic [MAX_PKTS-1:0] pend [N_SLOTS];
   logic [PKT_W-1:0]    lidx [N_SLOTS];
   logic [LEN_W-1:0]    llen [N_SLOTS];

   logic                sel_any;
   logic [SLOT_W-1:0]   sel_slot;
   logic                pkt_any;
   logic [PKT_W-1:0]    sel_pkt;
   logic                send;
   ev_op_e              op;

   assign op = ev_op_e'(ev_op);

   msgtx_intake #(
      .N_SLOTS   (N_SLOTS),
      .MAX_PKTS  (MAX_PKTS),
      .MTU_WORDS (MTU_WORDS)
   ) u_intake (
      .clk       (clk),
      .rst_n     (rst_n),
      .msg_valid (msg_valid),
      .msg_last  (msg_last),
      .msg_ready (msg_ready),
      .free_mask (~act),
      .alloc     (alloc),
      .tgt_slot  (tgt_slot),
      .close     (close),
      .close_idx (close_idx),
      .close_len (close_len),
      .close_end (close_end)
   );

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      logic hit_me;
      assign hit_me = (tgt_slot == SLOT_W'(s));

      msgtx_slot #(
         .MAX_PKTS    (MAX_PKTS),
         .MTU_WORDS   (MTU_WORDS),
         .INIT_CREDIT (INIT_CREDIT)
      ) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .alloc_i     (alloc & hit_me),
         .close_i     (close & hit_me),
         .close_idx_i (close_idx),
         .close_len_i (close_len),
         .close_end_i (close_end),
         .ev_hit_i    (ev_valid && ev_slot == SLOT_W'(s)),
         .ev_op_i     (op),
         .ev_pkt_i    (ev_pkt),
         .to_hit_i    (to_valid && to_slot == SLOT_W'(s)),
         .send_i      (send && sel_slot == SLOT_W'(s)),
         .send_idx_i  (sel_pkt),
         .free_i      (tcancel_valid && tcancel_slot == SLOT_W'(s)),
         .active_o    (act[s]),
         .pend_o      (pend[s]),
         .done_o      (done[s]),
         .rx_done_o   (rxd[s]),
         .last_idx_o  (lidx[s]),
         .last_len_o  (llen[s])
      );

      assign has_pend[s] = |pend[s];
   end

   msgtx_pick #(.N(N_SLOTS)) u_slot_pick (
      .req (has_pend),
      .any (sel_any),
      .idx (sel_slot)
   );

   msgtx_pick #(.N(MAX_PKTS)) u_pkt_pick (
      .req (pend[sel_slot]),
      .any (pkt_any),
      .idx (sel_pkt)
   );

   msgtx_pick #(.N(N_SLOTS)) u_done_pick (
      .req (done),
      .any (tcancel_valid),
      .idx (tcancel_slot)
   );

   assign desc_valid   = sel_any & pkt_any;
   assign desc_slot    = sel_slot;
   assign desc_pkt     = sel_pkt;
   assign desc_last    = rxd[sel_slot] && (lidx[sel_slot] == sel_pkt);
   assign desc_words   = desc_last ? llen[sel_slot] : LEN_W'(MTU_WORDS);
   assign send         = desc_valid & desc_ready;
   assign tstart_valid = alloc;
   assign tstart_slot  = tgt_slot;

   a_r6_lowest_slot : assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> ((has_pend & ((N_SLOTS'(1) << desc_slot) - N_SLOTS'(1))) == '0));

   a_r10_cancel_frees : assert property (@(posedge clk) disable iff (!rst_n)
      tcancel_valid |=> !act[$past(tcancel_slot)]);

   a_r2_start_claims : assert property (@(posedge clk) disable iff (!rst_n)
      tstart_valid |=> act[$past(tstart_slot)]);

   a_r11_stall_full : assert property (@(posedge clk) disable iff (!rst_n)
      !msg_ready |-> (&act));

endmodule

// File: tb/sim_msg_tx_tracker.sv
`timescale 1ns/1ps
module sim_msg_tx_tracker;

   localparam int NS   = 4;
   localparam int NP   = 8;
   localparam int MTU  = 4;
   localparam int ICR  = 2;
   localparam int SW   = $clog2(NS);
   localparam int PW   = $clog2(NP);
   localparam int LW   = $clog2(MTU + 1);
   localparam int NVEC = 7;
   // message words, expected packet count, expected last packet words
   localparam int VEC [NVEC][3] = '{
      '{1, 1, 1}, '{3, 1, 3}, '{4, 1, 4}, '{5, 2, 1},
      '{8, 2, 4}, '{13, 4, 1}, '{32, 8, 4}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          msg_valid = 1'b0;
   logic          msg_last = 1'b0;
   logic          msg_ready;
   logic          ev_valid = 1'b0;
   logic [1:0]    ev_op = 2'b11;
   logic [SW-1:0] ev_slot = '0;
   logic [PW-1:0] ev_pkt = '0;
   logic          to_valid = 1'b0;
   logic [SW-1:0] to_slot = '0;
   logic          desc_valid;
   logic          desc_ready = 1'b0;
   logic [SW-1:0] desc_slot;
   logic [PW-1:0] desc_pkt;
   logic [LW-1:0] desc_words;
   logic          desc_last;
   logic          tstart_valid;
   logic [SW-1:0] tstart_slot;
   logic          tcancel_valid;
   logic [SW-1:0] tcancel_slot;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   msg_tx_tracker #(
      .N_SLOTS(NS), .MAX_PKTS(NP), .MTU_WORDS(MTU), .INIT_CREDIT(ICR)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .msg_valid(msg_valid), .msg_last(msg_last), .msg_ready(msg_ready),
      .ev_valid(ev_valid), .ev_op(ev_op), .ev_slot(ev_slot), .ev_pkt(ev_pkt),
      .to_valid(to_valid), .to_slot(to_slot),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_slot(desc_slot),
      .desc_pkt(desc_pkt), .desc_words(desc_words), .desc_last(desc_last),
      .tstart_valid(tstart_valid), .tstart_slot(tstart_slot),
      .tcancel_valid(tcancel_valid), .tcancel_slot(tcancel_slot)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic send_msg(input int words, input int exp_slot);
      for (int i = 0; i < words; i++) begin
         @(negedge clk);
         msg_valid = 1'b1;
         msg_last  = (i == words - 1);
         #1;
         chk("R11 msg_ready open", int'(msg_ready), 1);
         if (i == 0) begin
            chk("R2 tstart_valid", int'(tstart_valid), 1);
            chk("R2 tstart_slot", int'(tstart_slot), exp_slot);
         end
      end
      @(negedge clk);
      msg_valid = 1'b0;
      msg_last  = 1'b0;
   endtask

   task automatic send_ev(input logic [1:0] op, input int slot, input int pkt);
      @(negedge clk);
      ev_valid = 1'b1;
      ev_op    = op;
      ev_slot  = SW'(slot);
      ev_pkt   = PW'(pkt);
      @(negedge clk);
      ev_valid = 1'b0;
      ev_op    = 2'b11;
   endtask

   task automatic pull(input string req, input int slot, input int pkt,
                       input int words, input int last);
      @(negedge clk);
      #1;
      chk({req, " desc_valid"}, int'(desc_valid), 1);
      chk({req, " desc_slot"}, int'(desc_slot), slot);
      chk({req, " desc_pkt"}, int'(desc_pkt), pkt);
      chk({req, " desc_words"}, int'(desc_words), words);
      chk({req, " desc_last"}, int'(desc_last), last);
      desc_ready = 1'b1;
      @(negedge clk);
      desc_ready = 1'b0;
   endtask

   task automatic expect_idle(input string req);
      @(negedge clk);
      #1;
      chk({req, " no descriptor"}, int'(desc_valid), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 desc_valid", int'(desc_valid), 0);
      chk("R1 tstart_valid", int'(tstart_valid), 0);
      chk("R1 tcancel_valid", int'(tcancel_valid), 0);
      chk("R1 msg_ready", int'(msg_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 msg_ready after release", int'(msg_ready), 1);
      chk("R1 desc_valid after release", int'(desc_valid), 0);

      // Table: R3 packetization and lengths, R10 release on full delivery
      for (int v = 0; v < NVEC; v++) begin
         send_msg(VEC[v][0], 0);
         send_ev(2'b01, 0, NP - 1);
         for (int p = 0; p < VEC[v][1]; p++) begin
            pull("R3", 0, p, (p == VEC[v][1] - 1) ? VEC[v][2] : MTU,
                 (p == VEC[v][1] - 1) ? 1 : 0);
         end
         expect_idle("R6");
         for (int p = 0; p < VEC[v][1]; p++) begin
            send_ev(2'b00, 0, p);
            #1;
            chk("R10 cancel timing", int'(tcancel_valid), (p == VEC[v][1] - 1) ? 1 : 0);
         end
         chk("R10 cancel slot", int'(tcancel_slot), 0);
         @(negedge clk);
         #1;
         chk("R10 cancel single pulse", int'(tcancel_valid), 0);
      end

      // R4 initial credit, R5 credit grant
      send_msg(13, 0);
      pull("R4", 0, 0, MTU, 0);
      pull("R4", 0, 1, MTU, 0);
      expect_idle("R4");
      send_ev(2'b01, 0, 2);
      pull("R5", 0, 2, MTU, 0);
      expect_idle("R5");
      // R6 ordering across slots
      send_msg(3, 1);
      send_ev(2'b01, 0, 3);
      pull("R6", 0, 3, 1, 1);
      pull("R6", 1, 0, 3, 1);
      expect_idle("R6");

      // R8 ack, R7 retransmit rules
      send_ev(2'b00, 0, 0);
      send_ev(2'b10, 0, 0);
      expect_idle("R7 delivered packet");
      send_ev(2'b10, 0, 5);
      expect_idle("R7 unformed packet");
      send_ev(2'b10, 0, 1);
      pull("R7", 0, 1, MTU, 0);
      expect_idle("R7");

      // R12 ignored events
      send_ev(2'b11, 0, 2);
      expect_idle("R12 no-op opcode");
      send_ev(2'b10, 2, 0);
      expect_idle("R12 inactive slot");
      send_ev(2'b11, 0, 3);
      #1;
      chk("R12 no cancel", int'(tcancel_valid), 0);

      // R9 timeout re-pends undelivered packets (0 was acknowledged: R8)
      @(negedge clk);
      to_valid = 1'b1;
      to_slot  = 0;
      @(negedge clk);
      to_valid = 1'b0;
      pull("R9", 0, 1, MTU, 0);
      pull("R9", 0, 2, MTU, 0);
      pull("R9", 0, 3, 1, 1);
      expect_idle("R9");

      // R10 cancel after final ack
      send_ev(2'b00, 0, 1);
      #1;
      chk("R10 early cancel", int'(tcancel_valid), 0);
      send_ev(2'b00, 0, 2);
      send_ev(2'b00, 0, 3);
      #1;
      chk("R10 cancel valid", int'(tcancel_valid), 1);
      chk("R10 cancel slot", int'(tcancel_slot), 0);

      // R11 backpressure when all slots busy
      send_msg(1, 0);
      send_msg(1, 2);
      send_msg(1, 3);
      @(negedge clk);
      msg_valid = 1'b1;
      msg_last  = 1'b1;
      #1;
      chk("R11 msg_ready stalled", int'(msg_ready), 0);
      chk("R11 no tstart", int'(tstart_valid), 0);
      @(negedge clk);
      msg_valid = 1'b0;
      msg_last  = 1'b0;
      send_ev(2'b00, 1, 0);
      #1;
      chk("R10 cancel slot1", int'(tcancel_valid), 1);
      chk("R10 cancel slot1 id", int'(tcancel_slot), 1);
      send_msg(1, 1);

      finish_run();
   end

endmodule